// File: doc/BRIEF.md
# Single-Operand ALU with Condition Codes

This unit runs the single-operand data operations of a 16-bit minicomputer datapath. Each accepted request carries an operation code, a byte-mode bit, a 16-bit operand and the current N, Z, V and C flags. One clock later the unit returns the result, the new flag set and a valid strobe.

The operations cover clearing, one's complement, increment, decrement, negate and test. They also include arithmetic shifts, rotates through the carry, byte swap, add and subtract of the incoming carry, and sign extension from the incoming N flag. In byte mode the arithmetic uses only the low eight bits, and the high byte of the operand passes through unchanged. Operand addressing, memory traffic and instruction fetch belong to the surrounding pipeline.

Top module: `sop_alu`

## Requirements
- R1: Outputs are registered. When `in_valid` is high at a rising edge, `result`, `flags_out` and `out_valid`=1 appear after that edge. When `in_valid` is low, `out_valid` goes low and `result` and `flags_out` hold their values. The asynchronous active-low reset clears all three outputs.
- R2: `op` codes are 0 clear, 1 complement, 2 increment, 3 decrement, 4 negate, 5 test, 6 shift right arithmetic, 7 shift left, 8 rotate right, 9 rotate left, 10 swap bytes, 11 add carry, 12 subtract carry and 13 sign extend. When `byte_mode` is high, every code except 10 and 13 works on bits 7:0 only, and result bits 15:8 equal operand bits 15:8.
- R3: The flag buses are ordered {N,Z,V,C} with N at bit 3 and C at bit 0. Z is 1 exactly when the active width of the result is zero. N is the top bit of the active width (bit 15 for words, bit 7 for bytes).
- R4: Clear returns zero with flags 0100. Test returns the operand unchanged with N and Z taken from it and V=C=0.
- R5: Complement inverts the active bits and sets C=1 and V=0.
- R6: Increment and decrement keep C from `flags_in`. Increment sets V when the result is the most negative value. Decrement sets V when the operand was the most negative value.
- R7: Negate forms the two's complement. It sets C unless the result is zero, and sets V only when the result is the most negative value.
- R8: Shift right keeps the sign bit. Shift left fills with 0. In both shifts, C receives the bit shifted out.
- R9: Rotates move the incoming C into the vacated end, and the bit shifted out becomes the new C.
- R10: For both shifts and both rotates, V equals new N XOR new C.
- R11: Swap exchanges the two bytes regardless of `byte_mode`. N and Z come from the low byte of the result, and V=C=0.
- R12: Add carry adds the incoming C. V is set when 0x7FFF (0x7F) becomes most negative, and C is set when all ones wraps to zero. Subtract carry subtracts the incoming C. V is set when the most negative value is decremented, and C is set when zero borrows.
- R13: Sign extend writes all ones if incoming N is 1 and zero otherwise, regardless of `byte_mode`. N is kept, Z = not N, V=0, and C is kept.
- R14: Codes 14 and 15 behave as test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| op | input | 4 | Operation code |
| byte_mode | input | 1 | Restrict operation to low byte |
| operand | input | 16 | Operand value |
| flags_in | input | 4 | Incoming {N,Z,V,C} |
| result | output | 16 | Registered result |
| flags_out | output | 4 | Registered new {N,Z,V,C} |
| out_valid | output | 1 | Result strobe, one cycle after request |

## Verification
The embedded assertions check the following on every cycle: the one-cycle valid timing and output hold, preservation of the high byte in byte mode, the fixed outcome of clear, the carry kept by increment and decrement, and the V = N XOR C rule for shifts and rotates. The value-level behaviour needs concrete operands and is shown only by the bench's vector table and directed cases. That behaviour covers the overflow and carry corners of negate, add carry and subtract carry, carry feeding through rotates, byte swap flagging, sign extension and the reset state.

// File: rtl/sop_alu.sv
module sop_alu #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [3:0]   op,
  input  logic         byte_mode,
  input  logic [W-1:0] operand,
  input  logic [3:0]   flags_in,
  output logic [W-1:0] result,
  output logic [3:0]   flags_out,
  output logic         out_valid
);
  localparam int H = W / 2;
  localparam logic [3:0] OP_CLR = 4'd0,  OP_COM = 4'd1,  OP_INC = 4'd2,  OP_DEC = 4'd3;
  localparam logic [3:0] OP_NEG = 4'd4,  OP_TST = 4'd5,  OP_ASR = 4'd6,  OP_ASL = 4'd7;
  localparam logic [3:0] OP_ROR = 4'd8,  OP_ROL = 4'd9,  OP_SWB = 4'd10, OP_ADC = 4'd11;
  localparam logic [3:0] OP_SBC = 4'd12, OP_SXT = 4'd13;

  logic         eff_byte, cin, nin, a_top, shift_grp;
  logic [W-1:0] fm, sm, a, t;
  logic         c_n, v_raw, n_n, z_n, v_n;

  assign cin      = flags_in[0];
  assign nin      = flags_in[3];
  assign eff_byte = byte_mode && (op != OP_SWB) && (op != OP_SXT);
  assign fm       = eff_byte ? {{(W-H){1'b0}}, {H{1'b1}}} : {W{1'b1}};
  assign sm       = eff_byte ? (W'(1) << (H-1)) : (W'(1) << (W-1));
  assign a        = operand & fm;
  assign a_top    = |(a & sm);
  assign shift_grp = (op == OP_ASR) || (op == OP_ASL) || (op == OP_ROR) || (op == OP_ROL);

  always_comb begin
    t     = a;
    c_n   = 1'b0;
    v_raw = 1'b0;
    case (op)
      OP_CLR: t = '0;
      OP_COM: begin t = ~a & fm; c_n = 1'b1; end
      OP_INC: begin t = (a + W'(1)) & fm; v_raw = (t == sm); c_n = cin; end
      OP_DEC: begin t = (a - W'(1)) & fm; v_raw = (a == sm); c_n = cin; end
      OP_NEG: begin t = (-a) & fm; v_raw = (t == sm); c_n = (t != '0); end
      OP_ASR: begin t = (a >> 1) | (a & sm); c_n = a[0]; end
      OP_ASL: begin t = (a << 1) & fm; c_n = a_top; end
      OP_ROR: begin t = (a >> 1) | (cin ? sm : '0); c_n = a[0]; end
      OP_ROL: begin t = ((a << 1) | W'(cin)) & fm; c_n = a_top; end
      OP_SWB: t = {operand[H-1:0], operand[W-1:H]};
      OP_ADC: begin
        t     = (a + W'(cin)) & fm;
        v_raw = cin && (t == sm);
        c_n   = cin && (a == fm);
      end
      OP_SBC: begin
        t     = (a - W'(cin)) & fm;
        v_raw = cin && (a == sm);
        c_n   = cin && (a == '0);
      end
      OP_SXT: begin t = nin ? {W{1'b1}} : '0; c_n = cin; end
      default: t = a;
    endcase
  end

  always_comb begin
    if (op == OP_SWB) begin
      n_n = t[H-1];
      z_n = (t[H-1:0] == '0);
    end else if (op == OP_SXT) begin
      n_n = nin;
      z_n = !nin;
    end else begin
      n_n = |(t & sm);
      z_n = ((t & fm) == '0);
    end
  end

  assign v_n = shift_grp ? (n_n ^ c_n) : v_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result    <= '0;
      flags_out <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= eff_byte ? {operand[W-1:H], t[H-1:0]} : t;
        flags_out <= {n_n, z_n, v_n, c_n};
      end
    end
  end

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result) && $stable(flags_out)));
  assert_high_byte_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && byte_mode && op != OP_SWB && op != OP_SXT)
      |=> result[W-1:H] == $past(operand[W-1:H]));
  assert_clear_outcome_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_CLR) |=> (flags_out == 4'b0100 && result[H-1:0] == '0));
  assert_incdec_carry_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op == OP_INC || op == OP_DEC)) |=> flags_out[0] == $past(flags_in[0]));
  assert_shift_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op == OP_ASR || op == OP_ASL || op == OP_ROR || op == OP_ROL))
      |=> flags_out[1] == (flags_out[3] ^ flags_out[0]));
endmodule

// File: tb/sop_alu_bench.sv
module sop_alu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  op = '0;
  logic        byte_mode = 1'b0;
  logic [15:0] operand = '0;
  logic [3:0]  flags_in = '0;
  logic [15:0] result;
  logic [3:0]  flags_out;
  logic        out_valid;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sop_alu u_sop_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .byte_mode(byte_mode),
    .operand(operand), .flags_in(flags_in), .result(result),
    .flags_out(flags_out), .out_valid(out_valid)
  );

  // {op, byte, operand, flags_in, expected result, expected flags}
  localparam int NV = 33;
  localparam logic [44:0] VEC [0:NV-1] = '{
    {4'd0,  1'b0, 16'h1234, 4'hF, 16'h0000, 4'h4},
    {4'd0,  1'b1, 16'h1234, 4'hF, 16'h1200, 4'h4},
    {4'd1,  1'b0, 16'h0000, 4'h0, 16'hFFFF, 4'h9},
    {4'd1,  1'b1, 16'h12F0, 4'h0, 16'h120F, 4'h1},
    {4'd2,  1'b0, 16'h7FFF, 4'h1, 16'h8000, 4'hB},
    {4'd2,  1'b1, 16'h00FF, 4'h0, 16'h0000, 4'h4},
    {4'd3,  1'b0, 16'h8000, 4'h0, 16'h7FFF, 4'h2},
    {4'd3,  1'b0, 16'h0001, 4'h1, 16'h0000, 4'h5},
    {4'd4,  1'b0, 16'h0000, 4'hF, 16'h0000, 4'h4},
    {4'd4,  1'b0, 16'h8000, 4'h0, 16'h8000, 4'hB},
    {4'd4,  1'b1, 16'hAB01, 4'h0, 16'hABFF, 4'h9},
    {4'd5,  1'b0, 16'h8000, 4'hF, 16'h8000, 4'h8},
    {4'd5,  1'b1, 16'hFF00, 4'h0, 16'hFF00, 4'h4},
    {4'd6,  1'b0, 16'h8001, 4'h0, 16'hC000, 4'h9},
    {4'd6,  1'b1, 16'h0081, 4'h0, 16'h00C0, 4'h9},
    {4'd7,  1'b0, 16'h4000, 4'h0, 16'h8000, 4'hA},
    {4'd7,  1'b1, 16'h0180, 4'h0, 16'h0100, 4'h7},
    {4'd8,  1'b0, 16'h0001, 4'h1, 16'h8000, 4'h9},
    {4'd8,  1'b0, 16'h0002, 4'h0, 16'h0001, 4'h0},
    {4'd9,  1'b0, 16'h8000, 4'h0, 16'h0000, 4'h7},
    {4'd9,  1'b1, 16'h5540, 4'h1, 16'h5581, 4'hA},
    {4'd10, 1'b1, 16'h1280, 4'hF, 16'h8012, 4'h0},
    {4'd10, 1'b0, 16'h00FF, 4'h0, 16'hFF00, 4'h4},
    {4'd11, 1'b0, 16'h7FFF, 4'h1, 16'h8000, 4'hA},
    {4'd11, 1'b0, 16'hFFFF, 4'h1, 16'h0000, 4'h5},
    {4'd11, 1'b1, 16'h12FF, 4'h0, 16'h12FF, 4'h8},
    {4'd12, 1'b0, 16'h0000, 4'h1, 16'hFFFF, 4'h9},
    {4'd12, 1'b0, 16'h8000, 4'h1, 16'h7FFF, 4'h2},
    {4'd12, 1'b1, 16'h3480, 4'h1, 16'h347F, 4'h2},
    {4'd13, 1'b0, 16'h1234, 4'h8, 16'hFFFF, 4'h8},
    {4'd13, 1'b0, 16'h1234, 4'h1, 16'h0000, 4'h5},
    {4'd13, 1'b1, 16'h0034, 4'h8, 16'hFFFF, 4'h8},
    {4'd14, 1'b0, 16'h0000, 4'hF, 16'h0000, 4'h4}
  };

  function automatic string req_of(input logic [3:0] o, input logic b);
    if (b && o != 4'd10 && o != 4'd13) return "R2";
    case (o)
      4'd0, 4'd5: return "R4";
      4'd1: return "R5";
      4'd2, 4'd3: return "R6";
      4'd4: return "R7";
      4'd6, 4'd7: return "R8";
      4'd8, 4'd9: return "R9";
      4'd10: return "R11";
      4'd11, 4'd12: return "R12";
      4'd13: return "R13";
      default: return "R14";
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] r, input logic [3:0] f,
                       input logic v, input logic [15:0] er, input logic [3:0] ef, input logic ev);
    n_chk++;
    if (r !== er || f !== ef || v !== ev) begin
      n_bad++;
      $display("FAIL %s: got result=%h flags=%h valid=%b, expected result=%h flags=%h valid=%b",
               req, r, f, v, er, ef, ev);
    end
  endtask

  initial begin
    logic [15:0] last_r;
    logic [3:0]  last_f;
    repeat (3) @(negedge clk);
    check("R1", result, flags_out, out_valid, 16'h0000, 4'h0, 1'b0); // reset state
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {op, byte_mode, operand, flags_in} = VEC[i][44:20];
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check(req_of(VEC[i][44:41], VEC[i][40]), result, flags_out, out_valid,
            VEC[i][19:4], VEC[i][3:0], 1'b1);
    end
    // R1: idle cycles keep outputs and drop the strobe, even with new inputs present
    last_r = result;
    last_f = flags_out;
    @(negedge clk);
    op = 4'd1; operand = 16'h5A5A; flags_in = 4'h0; byte_mode = 1'b0;
    @(negedge clk);
    check("R1", result, flags_out, out_valid, last_r, last_f, 1'b0);
    // R3: byte-mode Z ignores a nonzero high byte, N follows bit 7
    op = 4'd5; byte_mode = 1'b1; operand = 16'hFF80; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R3", result, flags_out, out_valid, 16'hFF80, 4'h8, 1'b1);
    // R9: back-to-back rotate left through carry in word mode
    op = 4'd9; byte_mode = 1'b0; operand = 16'hC000; flags_in = 4'h0; in_valid = 1'b1;
    @(negedge clk);
    check("R9", result, flags_out, out_valid, 16'h8000, 4'h9, 1'b1);
    operand = 16'h8000; flags_in = 4'h1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9", result, flags_out, out_valid, 16'h0001, 4'h3, 1'b1);
    // R1: reset mid-stream clears everything
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", result, flags_out, out_valid, 16'h0000, 4'h0, 1'b0);
    rst_n = 1'b1;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule